// File: doc/BRIEF.md
# Block Data Transfer FIFO Engine

This block carries the data phase of a block-oriented card transfer. When a transfer starts it computes the total byte count as the block count multiplied by the block length. It then moves bytes one at a time between a host-side register port and a byte-wide card data port. Toward the card, it drains a transmit byte ring that the host fills. From the card, it fills a receive byte ring that the host empties. Host accesses carry 1 to 4 bytes at once, packed most-significant lane first. The block keeps service-request flags for each ring and completion flags for the transfer.

The host side is a plain strobe interface: a push strobe with a lane count and a data word, and a pop strobe with a lane count. The pop data appears combinationally in the same cycle. The card side uses a valid/ready handshake in each direction and moves one byte per cycle. A partial-buffer flush throws away whatever the transmit ring holds and switches it to its other storage half. Command issue, CRC and the card physical layer belong to other blocks.

Top module: `blkxfer_engine`

## Requirements
- R1: At reset, and in the cycle after `xfer_start`, `tx_level` and `rx_level` are 0. After `xfer_start`, `bytes_left` equals `blk_count*blk_len`, `busy` is 1, and `data_done`, `prog_done` and `rx_req` are 0. Start takes precedence over every other input in its cycle.
- R2: In a write transfer, `card_tx_valid` is 1 exactly when the block is busy, `tx_level` is above 0 and `bytes_left` is above 0. Each accepted byte is the oldest byte held, and the handshake lowers both `tx_level` and `bytes_left` by one.
- R3: In a write transfer, `tx_req` goes to 0 in the cycle after a host push. In any other cycle it is set whenever bytes remain after that cycle, and it holds until the next push or start.
- R4: In a read transfer, `card_rx_ready` is 1 exactly when the block is busy, `rx_level` is below the ring depth and `bytes_left` is above 0. Each accepted byte enters the receive ring, lowers `bytes_left` by one and sets `rx_req`.
- R5: At the edge where `bytes_left` reaches 0, `busy` falls and `data_done` rises. `prog_done` rises only for a write transfer. Both flags hold until the next start, and a start with a product of 0 finishes in that same edge.
- R6: Ring positions wrap modulo the depth (32), so byte order is kept across the wrap in both directions.
- R7: A host pop of N lanes clamps N to 4. The first byte removed appears in lane N-1 (bits 8N-1 down to 8N-8), and the following bytes fill lower lanes. Lanes beyond the bytes held read 0. `rx_level` drops by min(N, level). A pop clears `rx_req` unless a card byte is accepted in the same cycle.
- R8: A host push of N lanes clamps N to 4. It enters lane N-1 first and lane 0 last. Bytes that would exceed 32 held are dropped, so `tx_level` rises by min(N, 32-level).
- R9: `buf_flush` sets `tx_level` to 0 and discards the bytes held (including a push in the same cycle) without changing `bytes_left`. Bytes pushed afterwards are delivered in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Begin a transfer (one-cycle strobe) |
| xfer_is_write | input | 1 | 1 = host-to-card transfer, 0 = card-to-host |
| blk_count | input | 16 | Number of blocks |
| blk_len | input | 12 | Bytes per block |
| buf_flush | input | 1 | Partial-buffer flush of the transmit ring |
| tx_push | input | 1 | Host push strobe |
| tx_push_len | input | 3 | Lanes in the push (1..4, larger clamps to 4) |
| tx_push_data | input | 32 | Push data, lane N-1 sent first |
| rx_pop | input | 1 | Host pop strobe |
| rx_pop_len | input | 3 | Lanes in the pop (1..4, larger clamps to 4) |
| rx_pop_data | output | 32 | Pop data, valid in the pop cycle |
| card_tx_valid | output | 1 | Byte offered to the card |
| card_tx_data | output | 8 | Byte offered to the card |
| card_tx_ready | input | 1 | Card accepts the offered byte |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Engine accepts the card byte |
| busy | output | 1 | Transfer in progress |
| tx_req | output | 1 | Transmit ring service request |
| rx_req | output | 1 | Receive ring service request |
| data_done | output | 1 | Transfer complete |
| prog_done | output | 1 | Write transfer complete |
| tx_level | output | 6 | Bytes held in the transmit ring |
| rx_level | output | 6 | Bytes held in the receive ring |
| bytes_left | output | 28 | Bytes remaining in the transfer |

## Verification
The bench builds the block at its default values: ring depth 32, four host lanes, and 16- and 12-bit count fields. Those values keep the full-ring and wrap cases within a few dozen cycles. Transfers of 48 and 40 bytes exceed the depth, so each ring wraps while data is still moving. The transmit ring is packed to exactly 32 bytes with mixed lane counts to reach the partial-drop case. Pop lengths of 0, 5 and lengths larger than the bytes held cover the clamp and the zero-filled lanes.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
    // Number of host lanes actually used for a request of req lanes.
    function automatic int unsigned lane_clamp(input int unsigned req, input int unsigned max_lanes);
        return (req > max_lanes) ? max_lanes : req;
    endfunction
endpackage

// File: rtl/xfr_ring_mem.sv
module xfr_ring_mem #(
    parameter int unsigned ENTRIES  = 32,
    parameter int unsigned WR_PORTS = 1,
    parameter int unsigned RD_PORTS = 1,
    localparam int unsigned AW = $clog2(ENTRIES)
) (
    input  logic                             clk,
    input  logic [WR_PORTS-1:0]              wr_en,
    input  logic [WR_PORTS-1:0][AW-1:0]      wr_addr,
    input  logic [WR_PORTS-1:0][7:0]         wr_data,
    input  logic [RD_PORTS-1:0][AW-1:0]      rd_addr,
    output logic [RD_PORTS-1:0][7:0]         rd_data
);
    logic [7:0] mem_q [ENTRIES];

    // Write ports never collide: the controller hands out consecutive slots.
    always_ff @(posedge clk) begin
        for (int p = 0; p < int'(WR_PORTS); p++) begin
            if (wr_en[p]) mem_q[wr_addr[p]] <= wr_data[p];
        end
    end

    for (genvar g = 0; g < int'(RD_PORTS); g++) begin : g_rd
        assign rd_data[g] = mem_q[rd_addr[g]];
    end
endmodule

// File: rtl/xfr_ctrl.sv
module xfr_ctrl #(
    parameter int unsigned DEPTH      = 32,
    parameter int unsigned HOST_BYTES = 4,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned LEN_W      = 12,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned LVL_W  = PTR_W + 1,
    localparam int unsigned LEFT_W = CNT_W + LEN_W,
    localparam int unsigned NB_W   = $clog2(HOST_BYTES + 1),
    localparam int unsigned TX_AW  = PTR_W + 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               xfer_start,
    input  logic                               xfer_is_write,
    input  logic [CNT_W-1:0]                   blk_count,
    input  logic [LEN_W-1:0]                   blk_len,
    input  logic                               buf_flush,
    input  logic                               tx_push,
    input  logic [NB_W-1:0]                    tx_push_len,
    input  logic [8*HOST_BYTES-1:0]            tx_push_data,
    input  logic                               rx_pop,
    input  logic [NB_W-1:0]                    rx_pop_len,
    output logic [8*HOST_BYTES-1:0]            rx_pop_data,
    output logic                               card_tx_valid,
    output logic [7:0]                         card_tx_data,
    input  logic                               card_tx_ready,
    input  logic                               card_rx_valid,
    input  logic [7:0]                         card_rx_data,
    output logic                               card_rx_ready,
    output logic                               busy,
    output logic                               tx_req,
    output logic                               rx_req,
    output logic                               data_done,
    output logic                               prog_done,
    output logic [LVL_W-1:0]                   tx_level,
    output logic [LVL_W-1:0]                   rx_level,
    output logic [LEFT_W-1:0]                  bytes_left,
    output logic [HOST_BYTES-1:0]              txm_wr_en,
    output logic [HOST_BYTES-1:0][TX_AW-1:0]   txm_wr_addr,
    output logic [HOST_BYTES-1:0][7:0]         txm_wr_data,
    output logic [0:0][TX_AW-1:0]              txm_rd_addr,
    input  logic [0:0][7:0]                    txm_rd_data,
    output logic [0:0]                         rxm_wr_en,
    output logic [0:0][PTR_W-1:0]              rxm_wr_addr,
    output logic [0:0][7:0]                    rxm_wr_data,
    output logic [HOST_BYTES-1:0][PTR_W-1:0]   rxm_rd_addr,
    input  logic [HOST_BYTES-1:0][7:0]         rxm_rd_data
);
    import xfr_pkg::*;

    typedef struct packed {
        logic              active;
        logic              is_wr;
        logic [LEFT_W-1:0] left;
        logic              tx_bank;
        logic [PTR_W-1:0]  tx_head;
        logic [LVL_W-1:0]  tx_len;
        logic [PTR_W-1:0]  rx_head;
        logic [LVL_W-1:0]  rx_len;
        logic              tx_req;
        logic              rx_req;
        logic              data_done;
        logic              prog_done;
    } xfr_state_t;

    xfr_state_t st_d, st_q;

    logic tx_go, rx_go, tx_pop, rx_push;
    logic [NB_W-1:0]  tx_n, rx_n;
    logic [LVL_W-1:0] tx_acc, rx_taken;
    logic [8*HOST_BYTES-1:0] rx_out;

    // Card-side handshakes depend on registered state only.
    assign tx_go   = st_q.active & st_q.is_wr & (st_q.tx_len != '0) & (st_q.left != '0);
    assign rx_go   = st_q.active & ~st_q.is_wr & (st_q.rx_len < LVL_W'(DEPTH)) & (st_q.left != '0);
    assign tx_pop  = tx_go & card_tx_ready & ~xfer_start;
    assign rx_push = rx_go & card_rx_valid & ~xfer_start;
    assign tx_n    = NB_W'(lane_clamp(int'(tx_push_len), HOST_BYTES));
    assign rx_n    = NB_W'(lane_clamp(int'(rx_pop_len), HOST_BYTES));

    always_comb begin
        st_d        = st_q;
        txm_wr_en   = '0;
        txm_wr_addr = '0;
        txm_wr_data = '0;
        tx_acc      = '0;
        rx_out      = '0;
        rx_taken    = '0;

        // Host push: lane n-1 first, stop once the ring is full.
        for (int i = 0; i < int'(HOST_BYTES); i++) begin
            if (tx_push && !xfer_start && !buf_flush && (NB_W'(i) < tx_n) &&
                ((st_q.tx_len + LVL_W'(i)) < LVL_W'(DEPTH))) begin
                txm_wr_en[i]   = 1'b1;
                txm_wr_addr[i] = {st_q.tx_bank, PTR_W'(st_q.tx_head + st_q.tx_len[PTR_W-1:0] + PTR_W'(i))};
                txm_wr_data[i] = tx_push_data[8*(int'(tx_n) - 1 - i) +: 8];
                tx_acc         = tx_acc + LVL_W'(1);
            end
        end

        // Host pop: oldest byte lands in the highest used lane.
        for (int i = 0; i < int'(HOST_BYTES); i++) begin
            rxm_rd_addr[i] = PTR_W'(st_q.rx_head + PTR_W'(i));
            if (rx_pop && !xfer_start && (NB_W'(i) < rx_n) && (LVL_W'(i) < st_q.rx_len)) begin
                rx_out[8*(int'(rx_n) - 1 - i) +: 8] = rxm_rd_data[i];
                rx_taken = rx_taken + LVL_W'(1);
            end
        end

        rxm_wr_en[0]   = rx_push;
        rxm_wr_addr[0] = PTR_W'(st_q.rx_head + st_q.rx_len[PTR_W-1:0]);
        rxm_wr_data[0] = card_rx_data;
        txm_rd_addr[0] = {st_q.tx_bank, st_q.tx_head};

        if (xfer_start) begin
            st_d.active    = 1'b1;
            st_d.is_wr     = xfer_is_write;
            st_d.left      = LEFT_W'(blk_count) * LEFT_W'(blk_len);
            st_d.tx_len    = '0;
            st_d.rx_len    = '0;
            st_d.tx_req    = 1'b0;
            st_d.rx_req    = 1'b0;
            st_d.data_done = 1'b0;
            st_d.prog_done = 1'b0;
        end else begin
            st_d.tx_head = st_q.tx_head + PTR_W'(tx_pop);
            st_d.tx_len  = st_q.tx_len - LVL_W'(tx_pop) + tx_acc;
            if (buf_flush) begin
                st_d.tx_bank = ~st_q.tx_bank;
                st_d.tx_len  = '0;
            end
            st_d.rx_head = st_q.rx_head + PTR_W'(rx_taken);
            st_d.rx_len  = st_q.rx_len - rx_taken + LVL_W'(rx_push);
            st_d.left    = st_q.left - LEFT_W'(tx_pop | rx_push);
            if (tx_push) st_d.tx_req = 1'b0;
            if (rx_pop)  st_d.rx_req = 1'b0;
            if (rx_push) st_d.rx_req = 1'b1;
        end

        if (st_d.active && (st_d.left == '0)) begin
            st_d.active    = 1'b0;
            st_d.data_done = 1'b1;
            st_d.prog_done = st_d.is_wr;
        end
        if (st_d.active && st_d.is_wr && (st_d.left != '0) && !(tx_push && !xfer_start))
            st_d.tx_req = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_pop_data   = rx_out;
    assign card_tx_valid = tx_go;
    assign card_tx_data  = txm_rd_data[0];
    assign card_rx_ready = rx_go;
    assign busy          = st_q.active;
    assign tx_req        = st_q.tx_req;
    assign rx_req        = st_q.rx_req;
    assign data_done     = st_q.data_done;
    assign prog_done     = st_q.prog_done;
    assign tx_level      = st_q.tx_len;
    assign rx_level      = st_q.rx_len;
    assign bytes_left    = st_q.left;

    // R2: a card handshake consumes exactly one byte of the count
    p_left_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !xfer_start && card_tx_valid && card_tx_ready)
        |=> (st_q.left == $past(st_q.left) - LEFT_W'(1)));

    // R4: an accepted card byte raises the receive request
    p_rx_req_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> st_q.rx_req);

    // R8: neither ring ever holds more than its depth
    p_level_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tx_len <= LVL_W'(DEPTH)) && (st_q.rx_len <= LVL_W'(DEPTH)));

    // R5: the last byte ends the transfer at that edge
    p_done_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !xfer_start && (st_q.left == LEFT_W'(1)) && (tx_pop || rx_push))
        |=> (!st_q.active && st_q.data_done));

    // R5: completion flag holds until the next start
    p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.data_done && !xfer_start) |=> st_q.data_done);

    // R9: a flush leaves the transmit ring empty
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_flush && !xfer_start) |=> (st_q.tx_len == '0));
endmodule

// File: rtl/blkxfer_engine.sv
module blkxfer_engine #(
    parameter int unsigned DEPTH      = 32,
    parameter int unsigned HOST_BYTES = 4,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned LEN_W      = 12,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned LVL_W  = PTR_W + 1,
    localparam int unsigned LEFT_W = CNT_W + LEN_W,
    localparam int unsigned NB_W   = $clog2(HOST_BYTES + 1),
    localparam int unsigned TX_AW  = PTR_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    xfer_start,
    input  logic                    xfer_is_write,
    input  logic [CNT_W-1:0]        blk_count,
    input  logic [LEN_W-1:0]        blk_len,
    input  logic                    buf_flush,
    input  logic                    tx_push,
    input  logic [NB_W-1:0]         tx_push_len,
    input  logic [8*HOST_BYTES-1:0] tx_push_data,
    input  logic                    rx_pop,
    input  logic [NB_W-1:0]         rx_pop_len,
    output logic [8*HOST_BYTES-1:0] rx_pop_data,
    output logic                    card_tx_valid,
    output logic [7:0]              card_tx_data,
    input  logic                    card_tx_ready,
    input  logic                    card_rx_valid,
    input  logic [7:0]              card_rx_data,
    output logic                    card_rx_ready,
    output logic                    busy,
    output logic                    tx_req,
    output logic                    rx_req,
    output logic                    data_done,
    output logic                    prog_done,
    output logic [LVL_W-1:0]        tx_level,
    output logic [LVL_W-1:0]        rx_level,
    output logic [LEFT_W-1:0]       bytes_left
);
    logic [HOST_BYTES-1:0]             txm_wr_en;
    logic [HOST_BYTES-1:0][TX_AW-1:0]  txm_wr_addr;
    logic [HOST_BYTES-1:0][7:0]        txm_wr_data;
    logic [0:0][TX_AW-1:0]             txm_rd_addr;
    logic [0:0][7:0]                   txm_rd_data;
    logic [0:0]                        rxm_wr_en;
    logic [0:0][PTR_W-1:0]             rxm_wr_addr;
    logic [0:0][7:0]                   rxm_wr_data;
    logic [HOST_BYTES-1:0][PTR_W-1:0]  rxm_rd_addr;
    logic [HOST_BYTES-1:0][7:0]        rxm_rd_data;

    xfr_ctrl #(.DEPTH(DEPTH), .HOST_BYTES(HOST_BYTES), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .xfer_start(xfer_start), .xfer_is_write(xfer_is_write),
        .blk_count(blk_count), .blk_len(blk_len), .buf_flush(buf_flush),
        .tx_push(tx_push), .tx_push_len(tx_push_len), .tx_push_data(tx_push_data),
        .rx_pop(rx_pop), .rx_pop_len(rx_pop_len), .rx_pop_data(rx_pop_data),
        .card_tx_valid(card_tx_valid), .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready),
        .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data), .card_rx_ready(card_rx_ready),
        .busy(busy), .tx_req(tx_req), .rx_req(rx_req),
        .data_done(data_done), .prog_done(prog_done),
        .tx_level(tx_level), .rx_level(rx_level), .bytes_left(bytes_left),
        .txm_wr_en(txm_wr_en), .txm_wr_addr(txm_wr_addr), .txm_wr_data(txm_wr_data),
        .txm_rd_addr(txm_rd_addr), .txm_rd_data(txm_rd_data),
        .rxm_wr_en(rxm_wr_en), .rxm_wr_addr(rxm_wr_addr), .rxm_wr_data(rxm_wr_data),
        .rxm_rd_addr(rxm_rd_addr), .rxm_rd_data(rxm_rd_data)
    );

    // Transmit storage is two halves so a flush can switch to fresh space.
    xfr_ring_mem #(.ENTRIES(2*DEPTH), .WR_PORTS(HOST_BYTES), .RD_PORTS(1)) u_tx_ring (
        .clk(clk), .wr_en(txm_wr_en), .wr_addr(txm_wr_addr), .wr_data(txm_wr_data),
        .rd_addr(txm_rd_addr), .rd_data(txm_rd_data)
    );

    xfr_ring_mem #(.ENTRIES(DEPTH), .WR_PORTS(1), .RD_PORTS(HOST_BYTES)) u_rx_ring (
        .clk(clk), .wr_en(rxm_wr_en), .wr_addr(rxm_wr_addr), .wr_data(rxm_wr_data),
        .rd_addr(rxm_rd_addr), .rd_data(rxm_rd_data)
    );
endmodule

// File: tb/tb_blkxfer_engine.sv
module tb_blkxfer_engine;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst_n, xfer_start, xfer_is_write, buf_flush;
    logic [15:0] blk_count;
    logic [11:0] blk_len;
    logic        tx_push, rx_pop;
    logic [2:0]  tx_push_len, rx_pop_len;
    logic [31:0] tx_push_data, rx_pop_data;
    logic        card_tx_valid, card_tx_ready, card_rx_valid, card_rx_ready;
    logic [7:0]  card_tx_data, card_rx_data;
    logic        busy, tx_req, rx_req, data_done, prog_done;
    logic [5:0]  tx_level, rx_level;
    logic [27:0] bytes_left;

    blkxfer_engine dut (.*);

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic idle_inputs();
        xfer_start = 0; xfer_is_write = 0; buf_flush = 0; blk_count = 0; blk_len = 0;
        tx_push = 0; tx_push_len = 0; tx_push_data = 0; rx_pop = 0; rx_pop_len = 0;
        card_tx_ready = 0; card_rx_valid = 0; card_rx_data = 0;
    endtask

    task automatic start_xfer(input bit wr, input int cnt, input int len);
        xfer_start = 1; xfer_is_write = wr; blk_count = 16'(cnt); blk_len = 12'(len);
        step();
        xfer_start = 0;
    endtask

    task automatic host_push(input int n, input logic [31:0] w);
        tx_push = 1; tx_push_len = 3'(n); tx_push_data = w;
        for (int i = n - 1; i >= 0; i--) if (txq.size() < 32) txq.push_back(w[8*i +: 8]);
        step();
        tx_push = 0;
    endtask

    task automatic drain(input int n);
        card_tx_ready = 1;
        for (int k = 0; k < n; k++) begin
            check("R2", "card_tx_valid while bytes held", card_tx_valid, 1);
            check("R6", "card byte order", card_tx_data, txq.pop_front());
            step();
        end
        card_tx_ready = 0;
    endtask

    task automatic t_reset_state();
        check("R1", "reset busy", busy, 0);
        check("R1", "reset tx_level", tx_level, 0);
        check("R1", "reset rx_level", rx_level, 0);
        check("R1", "reset bytes_left", bytes_left, 0);
        check("R5", "reset data_done", data_done, 0);
        check("R3", "reset tx_req", tx_req, 0);
    endtask

    task automatic t_zero_length();
        start_xfer(1, 3, 0);
        check("R5", "zero product busy", busy, 0);
        check("R5", "zero product data_done", data_done, 1);
        check("R5", "zero product prog_done", prog_done, 1);
        check("R1", "zero product bytes_left", bytes_left, 0);
    endtask

    task automatic t_write_burst();
        int lens[10] = '{4, 3, 2, 1, 4, 4, 4, 4, 4, 4};
        txq.delete();
        start_xfer(1, 2, 24);
        check("R1", "write start bytes_left", bytes_left, 48);
        check("R1", "write start busy", busy, 1);
        check("R1", "write start data_done", data_done, 0);
        check("R3", "tx_req raised after start", tx_req, 1);
        for (int k = 0; k < 10; k++) begin
            host_push(lens[k], {8'(k*16+3), 8'(k*16+2), 8'(k*16+1), 8'(k*16)});
            check("R8", "tx_level after push", tx_level, txq.size());
            if (k == 0) check("R3", "tx_req cleared by push", tx_req, 0);
        end
        check("R8", "ring full level", tx_level, 32);
        step();
        check("R3", "tx_req re-raised without push", tx_req, 1);
        drain(32);
        check("R2", "level after drain", tx_level, 0);
        check("R2", "bytes_left after 32 sent", bytes_left, 16);
        check("R2", "no valid when ring empty", card_tx_valid, 0);
        for (int k = 0; k < 4; k++) host_push(4, 32'hC0C1C2C3 + 32'(k) * 32'h04040404);
        drain(16);
        check("R5", "write busy after last byte", busy, 0);
        check("R5", "write data_done", data_done, 1);
        check("R5", "write prog_done", prog_done, 1);
        check("R5", "write bytes_left", bytes_left, 0);
    endtask

    task automatic t_read_burst();
        int pat[6] = '{4, 0, 3, 2, 5, 1};
        logic [7:0] src = 8'hA0;
        int recv = 0;
        int it = 0;
        rxq.delete();
        start_xfer(0, 5, 8);
        check("R4", "card_rx_ready after start", card_rx_ready, 1);
        check("R1", "read start rx_req", rx_req, 0);
        card_rx_valid = 1;
        for (int k = 0; k < 32; k++) begin
            card_rx_data = src;
            step();
            rxq.push_back(src); src++; recv++;
        end
        check("R4", "receive ring full", rx_level, 32);
        check("R4", "ready low when full", card_rx_ready, 0);
        check("R4", "rx_req set by card bytes", rx_req, 1);
        check("R4", "bytes_left after fill", bytes_left, 8);
        while ((recv < 40 || rxq.size() != 0) && it < 300) begin
            int n = pat[it % 6];
            int ne = (n > 4) ? 4 : n;
            int kk = (ne < rxq.size()) ? ne : rxq.size();
            logic [31:0] e = '0;
            bit hs;
            for (int i = 0; i < kk; i++) e[8*(ne-1-i) +: 8] = rxq[i];
            rx_pop = (n != 0); rx_pop_len = 3'(n); card_rx_data = src;
            #1;
            hs = card_rx_ready && card_rx_valid;
            if (n != 0) check("R7", "pop data lanes", rx_pop_data, e);
            step();
            for (int i = 0; i < kk; i++) void'(rxq.pop_front());
            if (hs) begin rxq.push_back(src); src++; recv++; end
            if (n != 0 && !hs) check("R7", "rx_req cleared by pop", rx_req, 0);
            if (hs) check("R4", "rx_req set by byte", rx_req, 1);
            check("R6", "rx_level tracks model", rx_level, rxq.size());
            rx_pop = 0;
            it++;
        end
        card_rx_valid = 0;
        check("R5", "read busy done", busy, 0);
        check("R5", "read data_done", data_done, 1);
        check("R5", "read prog_done stays low", prog_done, 0);
        rx_pop = 1; rx_pop_len = 4;
        #1;
        check("R7", "pop of empty ring reads zero", rx_pop_data, 0);
        step();
        rx_pop = 0;
        check("R7", "level stays zero", rx_level, 0);
    endtask

    task automatic t_flush();
        txq.delete();
        start_xfer(1, 1, 8);
        host_push(4, 32'h11223344);
        check("R8", "level before flush", tx_level, 4);
        txq.delete();
        buf_flush = 1;
        step();
        buf_flush = 0;
        check("R9", "flush empties ring", tx_level, 0);
        check("R9", "no card byte after flush", card_tx_valid, 0);
        check("R9", "flush keeps bytes_left", bytes_left, 8);
        host_push(4, 32'h55667788);
        host_push(4, 32'h99AABBCC);
        check("R9", "level after refill", tx_level, 8);
        drain(8);
        check("R9", "flushed transfer completes", data_done, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset_state();
        t_zero_length();
        t_write_burst();
        t_read_burst();
        t_flush();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule